// File: doc/BRIEF.md
# Home-Node Directory for MSI Coherence

This block is the home directory for a group of cache lines in a small shared-memory multiprocessor. The processors talk to it over a point-to-point network that does not keep messages in order. Each line it owns has an entry with three parts: a coherence state (Invalid, Shared or Modified), the owning processor while the line is Modified, and a bit-vector of the processors that hold a clean copy. The block also keeps a small data array that acts as the backing memory for those lines.

Processors send read or write requests. The directory answers a request directly from memory when no other cache has to act. Otherwise it sends a forward or invalidate message to the recorded holders, and only to them. It then waits until every expected acknowledgement has come back before it completes the request. A line with an open transaction is marked busy. Requests behind it wait in a four-entry queue, which gives one serialization point per line even though the network can reorder messages. An address belongs to this home when its upper bits match the home number, so the address space is split between homes by a fixed rule.

Top module: `dircoh_home`

## Requirements
- R1: After reset `rsp_valid_o` and `fwd_valid_o` are low, `req_ready_o` is high, every line is Invalid, and backing word k holds `MEM_BASE + k`.
- R2: A read to a line in Invalid or Shared is answered at once with the memory word and `rsp_excl_o` low. The requester is added to the sharers and the line becomes Shared.
- R3: A read to a line that another processor holds Modified produces one forward message (`fwd_read_o` = 1) whose mask has only the owner's bit set. The answer to the requester carries the owner's write-back data, which also updates memory. Old owner and requester become the sharers.
- R4: A write to a line that other processors hold sends one invalidate (`fwd_read_o` = 0) whose mask is exactly the holders minus the requester. The grant (`rsp_excl_o` = 1) follows only after all of them have acknowledged, and the requester becomes owner.
- R5: A write to a line with no other holder (Invalid, or the requester is the only sharer) is granted at once with `rsp_excl_o` = 1 and no forward message.
- R6: A request to a busy line waits in arrival order and is not acted on until the last acknowledgement of the earlier transaction has arrived.
- R7: The request queue holds four entries. While it is full, `req_ready_o` is low.
- R8: An address is `{home field, line index}`. A request whose home field differs from `HOME_ID` is dropped without any message.
- R9: An acknowledgement is counted only if it comes from a processor that is still owed one on a busy line. Repeats, acks for idle lines and their write-back data have no effect.
- R10: A response and a forward message never appear in the same cycle. When an acknowledgement completes a transaction, new dispatch waits one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Queue can take a request |
| req_src_i | input | PID_W | Requesting processor |
| req_write_i | input | 1 | 1 = write (exclusive) request, 0 = read |
| req_addr_i | input | ADDR_W | Line address `{home, index}` |
| ack_valid_i | input | 1 | Acknowledgement present |
| ack_src_i | input | PID_W | Acknowledging processor |
| ack_addr_i | input | ADDR_W | Line address of the acknowledgement |
| ack_wb_i | input | 1 | Acknowledgement carries write-back data |
| ack_data_i | input | DATA_W | Write-back data |
| fwd_valid_o | output | 1 | Forward/invalidate message, one cycle |
| fwd_mask_o | output | NPROC | Processors addressed by the message |
| fwd_read_o | output | 1 | 1 = forward a read to the owner, 0 = invalidate |
| fwd_addr_o | output | ADDR_W | Line address of the message |
| fwd_req_o | output | PID_W | Processor that made the request |
| rsp_valid_o | output | 1 | Response to a requester, one cycle |
| rsp_dst_o | output | PID_W | Processor receiving the response |
| rsp_addr_o | output | ADDR_W | Line address of the response |
| rsp_excl_o | output | 1 | 1 = exclusive (write) grant |
| rsp_data_o | output | DATA_W | Line data |

## Verification
A wrong sharer vector or owner shows up on the next request that touches the line. The forward mask then names the wrong processors, or a grant comes with no invalidation before it. A bad acknowledgement count or a lost busy flag shows up as a response that arrives before the last ack. It can also show as a queued request that is never served, or as stale data after an owner's write-back. The directed scenarios chain requests on each line so that every state change is observed by the request that follows it, within a few cycles.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_e;
endpackage

// File: rtl/dircoh_req_fifo.sv
module dircoh_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PTR_W-1:0]        wptr;
        logic [PTR_W-1:0]        rptr;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    assign data_o  = f_q.slot[f_q.rptr];
    assign empty_o = (f_q.cnt == '0);
    assign full_o  = (f_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        logic do_push, do_pop;
        f_d     = f_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            f_d.slot[f_q.wptr] = data_i;
            f_d.wptr = (f_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : f_q.wptr + 1'b1;
        end
        if (do_pop) begin
            f_d.rptr = (f_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : f_q.rptr + 1'b1;
        end
        if (do_push && !do_pop) f_d.cnt = f_q.cnt + 1'b1;
        else if (do_pop && !do_push) f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end
endmodule

// File: rtl/dircoh_target_sel.sv
module dircoh_target_sel
    import dircoh_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int PID_W = 2,
    parameter int CNT_W = 3
) (
    input  line_st_e         st_i,
    input  logic [PID_W-1:0] owner_i,
    input  logic [NPROC-1:0] sharers_i,
    input  logic [PID_W-1:0] src_i,
    input  logic             write_i,
    output logic [NPROC-1:0] mask_o,
    output logic             read_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [NPROC-1:0] src_bit, own_bit;

    assign src_bit = NPROC'(1) << src_i;
    assign own_bit = NPROC'(1) << owner_i;

    always_comb begin
        mask_o = '0;
        read_o = !write_i;
        if (write_i) begin
            if (st_i == LS_S)      mask_o = sharers_i & ~src_bit;
            else if (st_i == LS_M) mask_o = own_bit & ~src_bit;
        end else if (st_i == LS_M && owner_i != src_i) begin
            mask_o = own_bit;
        end
        cnt_o = '0;
        for (int p = 0; p < NPROC; p++) begin
            cnt_o = cnt_o + CNT_W'(mask_o[p]);
        end
    end
endmodule

// File: rtl/dircoh_home.sv
module dircoh_home
    import dircoh_pkg::*;
#(
    parameter int          NPROC     = 4,
    parameter int          NLINES    = 4,
    parameter int          DATA_W    = 32,
    parameter int          HOME_BITS = 1,
    parameter int          HOME_ID   = 1,
    parameter int          QDEPTH    = 4,
    parameter logic [31:0] MEM_BASE  = 32'h0000_A000,
    localparam int PID_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES),
    localparam int ADDR_W = LINE_W + HOME_BITS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [PID_W-1:0]  req_src_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              ack_valid_i,
    input  logic [PID_W-1:0]  ack_src_i,
    input  logic [ADDR_W-1:0] ack_addr_i,
    input  logic              ack_wb_i,
    input  logic [DATA_W-1:0] ack_data_i,
    output logic              fwd_valid_o,
    output logic [NPROC-1:0]  fwd_mask_o,
    output logic              fwd_read_o,
    output logic [ADDR_W-1:0] fwd_addr_o,
    output logic [PID_W-1:0]  fwd_req_o,
    output logic              rsp_valid_o,
    output logic [PID_W-1:0]  rsp_dst_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic              rsp_excl_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    localparam int CNT_W = $clog2(NPROC + 1);
    localparam int REQ_W = PID_W + 1 + LINE_W;
    localparam logic [HOME_BITS-1:0] HOME = HOME_BITS'(HOME_ID);

    typedef struct packed {
        line_st_e         st;
        logic [PID_W-1:0] owner;
        logic [NPROC-1:0] sharers;
        logic             busy;
        logic [CNT_W-1:0] pend_cnt;
        logic [NPROC-1:0] pend_mask;
        logic [PID_W-1:0] pend_src;
        logic             pend_wr;
    } entry_t;

    typedef struct packed {
        entry_t [NLINES-1:0]            ent;
        logic [NLINES-1:0][DATA_W-1:0]  mem;
        logic                           fwd_valid;
        logic [NPROC-1:0]               fwd_mask;
        logic                           fwd_read;
        logic [ADDR_W-1:0]              fwd_addr;
        logic [PID_W-1:0]               fwd_req;
        logic                           rsp_valid;
        logic [PID_W-1:0]               rsp_dst;
        logic [ADDR_W-1:0]              rsp_addr;
        logic                           rsp_excl;
        logic [DATA_W-1:0]              rsp_data;
    } dir_t;

    dir_t s_d, s_q;

    // request queue
    logic             q_push, q_pop, q_empty, q_full;
    logic [REQ_W-1:0] q_in, q_head;
    logic [PID_W-1:0] h_src;
    logic             h_wr;
    logic [LINE_W-1:0] h_line;

    assign q_push      = req_valid_i && !q_full
                         && (req_addr_i[ADDR_W-1 -: HOME_BITS] == HOME);
    assign q_in        = {req_src_i, req_write_i, req_addr_i[LINE_W-1:0]};
    assign req_ready_o = !q_full;
    assign {h_src, h_wr, h_line} = q_head;

    dircoh_req_fifo #(
        .W     (REQ_W),
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (q_push),
        .data_i  (q_in),
        .pop_i   (q_pop),
        .data_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    // who must be contacted for the request at the head
    entry_t           h_ent;
    logic [NPROC-1:0] t_mask;
    logic             t_read;
    logic [CNT_W-1:0] t_cnt;

    assign h_ent = s_q.ent[h_line];

    dircoh_target_sel #(
        .NPROC (NPROC),
        .PID_W (PID_W),
        .CNT_W (CNT_W)
    ) u_tsel (
        .st_i      (h_ent.st),
        .owner_i   (h_ent.owner),
        .sharers_i (h_ent.sharers),
        .src_i     (h_src),
        .write_i   (h_wr),
        .mask_o    (t_mask),
        .read_o    (t_read),
        .cnt_o     (t_cnt)
    );

    always_comb begin
        logic [LINE_W-1:0] a_line;
        logic              ack_ok;
        logic              ack_done;
        entry_t            ae;
        a_line   = ack_addr_i[LINE_W-1:0];
        ae       = s_q.ent[a_line];
        s_d      = s_q;
        s_d.fwd_valid = 1'b0;
        s_d.rsp_valid = 1'b0;
        q_pop    = 1'b0;
        ack_done = 1'b0;

        // acknowledgement path
        ack_ok = ack_valid_i && (ack_addr_i[ADDR_W-1 -: HOME_BITS] == HOME)
                 && ae.busy && ae.pend_mask[ack_src_i];
        if (ack_ok) begin
            s_d.ent[a_line].pend_mask[ack_src_i] = 1'b0;
            s_d.ent[a_line].pend_cnt = ae.pend_cnt - 1'b1;
            if (ack_wb_i) s_d.mem[a_line] = ack_data_i;
            if (ae.pend_cnt == CNT_W'(1)) begin
                ack_done = 1'b1;
                s_d.ent[a_line].busy = 1'b0;
                s_d.rsp_valid = 1'b1;
                s_d.rsp_dst   = ae.pend_src;
                s_d.rsp_addr  = {HOME, a_line};
                s_d.rsp_data  = ack_wb_i ? ack_data_i : s_q.mem[a_line];
                s_d.rsp_excl  = ae.pend_wr;
                if (ae.pend_wr) begin
                    s_d.ent[a_line].st      = LS_M;
                    s_d.ent[a_line].owner   = ae.pend_src;
                    s_d.ent[a_line].sharers = '0;
                end else begin
                    s_d.ent[a_line].st      = LS_S;
                    s_d.ent[a_line].sharers = (NPROC'(1) << ae.owner)
                                            | (NPROC'(1) << ae.pend_src);
                end
            end
        end

        // dispatch path: one message port use per cycle
        if (!q_empty && !h_ent.busy && !ack_done) begin
            q_pop = 1'b1;
            if (t_cnt == '0) begin
                s_d.rsp_valid = 1'b1;
                s_d.rsp_dst   = h_src;
                s_d.rsp_addr  = {HOME, h_line};
                s_d.rsp_data  = s_q.mem[h_line];
                s_d.rsp_excl  = h_wr;
                if (h_wr) begin
                    s_d.ent[h_line].st      = LS_M;
                    s_d.ent[h_line].owner   = h_src;
                    s_d.ent[h_line].sharers = '0;
                end else if (h_ent.st != LS_M) begin
                    s_d.ent[h_line].st      = LS_S;
                    s_d.ent[h_line].sharers = h_ent.sharers | (NPROC'(1) << h_src);
                end
            end else begin
                s_d.fwd_valid = 1'b1;
                s_d.fwd_mask  = t_mask;
                s_d.fwd_read  = t_read;
                s_d.fwd_addr  = {HOME, h_line};
                s_d.fwd_req   = h_src;
                s_d.ent[h_line].busy      = 1'b1;
                s_d.ent[h_line].pend_cnt  = t_cnt;
                s_d.ent[h_line].pend_mask = t_mask;
                s_d.ent[h_line].pend_src  = h_src;
                s_d.ent[h_line].pend_wr   = h_wr;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
            for (int k = 0; k < NLINES; k++) begin
                s_q.mem[k] <= DATA_W'(MEM_BASE + 32'(k));
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign fwd_valid_o = s_q.fwd_valid;
    assign fwd_mask_o  = s_q.fwd_mask;
    assign fwd_read_o  = s_q.fwd_read;
    assign fwd_addr_o  = s_q.fwd_addr;
    assign fwd_req_o   = s_q.fwd_req;
    assign rsp_valid_o = s_q.rsp_valid;
    assign rsp_dst_o   = s_q.rsp_dst;
    assign rsp_addr_o  = s_q.rsp_addr;
    assign rsp_excl_o  = s_q.rsp_excl;
    assign rsp_data_o  = s_q.rsp_data;
endmodule

// File: rtl/dircoh_home_chk.sv
module dircoh_home_chk #(
    parameter int NPROC = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_ready_o,
    input logic             q_full,
    input logic             fwd_valid_o,
    input logic [NPROC-1:0] fwd_mask_o,
    input logic             fwd_read_o,
    input logic             rsp_valid_o
);
    // R10
    port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rsp_valid_o && fwd_valid_o));

    // R7
    full_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_full |-> !req_ready_o);

    // R4
    fwd_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_valid_o |-> (fwd_mask_o != '0));

    // R3
    fwd_single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fwd_valid_o && fwd_read_o) |-> ($countones(fwd_mask_o) == 1));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_valid_o |=> !rsp_valid_o || !fwd_valid_o);
endmodule

bind dircoh_home dircoh_home_chk #(.NPROC(NPROC)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ready_o (req_ready_o),
    .q_full      (q_full),
    .fwd_valid_o (fwd_valid_o),
    .fwd_mask_o  (fwd_mask_o),
    .fwd_read_o  (fwd_read_o),
    .rsp_valid_o (rsp_valid_o)
);

// File: tb/dircoh_home_tb.sv
`timescale 1ns/1ps
module dircoh_home_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_addr = '0;
    logic        ack_valid = 1'b0, ack_wb = 1'b0;
    logic [1:0]  ack_src = '0;
    logic [2:0]  ack_addr = '0;
    logic [31:0] ack_data = '0;
    logic        req_ready, fwd_valid, fwd_read, rsp_valid, rsp_excl;
    logic [3:0]  fwd_mask;
    logic [2:0]  fwd_addr, rsp_addr;
    logic [1:0]  fwd_req, rsp_dst;
    logic [31:0] rsp_data;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [1:0]  g_dst;
    logic [31:0] g_data;
    logic        g_excl, g_ok, g_sawfwd;
    logic [3:0]  f_mask;
    logic        f_read, f_ok;
    logic [1:0]  f_req;

    always #2.5 clk = ~clk;

    dircoh_home u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_src_i(req_src),
        .req_write_i(req_write), .req_addr_i(req_addr),
        .ack_valid_i(ack_valid), .ack_src_i(ack_src), .ack_addr_i(ack_addr),
        .ack_wb_i(ack_wb), .ack_data_i(ack_data),
        .fwd_valid_o(fwd_valid), .fwd_mask_o(fwd_mask), .fwd_read_o(fwd_read),
        .fwd_addr_o(fwd_addr), .fwd_req_o(fwd_req),
        .rsp_valid_o(rsp_valid), .rsp_dst_o(rsp_dst), .rsp_addr_o(rsp_addr),
        .rsp_excl_o(rsp_excl), .rsp_data_o(rsp_data)
    );

    function automatic logic [2:0] ha(input int line);
        return {1'b1, 2'(line)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_req(input int src, input bit wr, input logic [2:0] addr);
        req_valid = 1'b1; req_src = 2'(src); req_write = wr; req_addr = addr;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_ack(input int src, input int line, input bit wb, input logic [31:0] d);
        ack_valid = 1'b1; ack_src = 2'(src); ack_addr = ha(line); ack_wb = wb; ack_data = d;
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0; ack_wb = 1'b0;
    endtask

    task automatic wait_rsp();
        g_ok = 0; g_sawfwd = 0;
        for (int i = 0; i < 20 && !g_ok; i++) begin
            if (fwd_valid) g_sawfwd = 1;
            if (rsp_valid) begin
                g_ok = 1; g_dst = rsp_dst; g_data = rsp_data; g_excl = rsp_excl;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_fwd();
        f_ok = 0;
        for (int i = 0; i < 20 && !f_ok; i++) begin
            if (fwd_valid) begin
                f_ok = 1; f_mask = fwd_mask; f_read = fwd_read; f_req = fwd_req;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_rsp(input string tag, input int dst, input logic [31:0] d, input bit ex);
        wait_rsp();
        chk(g_ok && g_dst == 2'(dst) && g_data == d && g_excl == ex, tag,
            {g_ok, 3'b0, g_excl, 2'b0, g_dst, g_data[23:0]},
            {1'b1, 3'b0, ex, 2'b0, 2'(dst), d[23:0]});
    endtask

    task automatic expect_fwd(input string tag, input logic [3:0] m, input bit rd, input int rq);
        wait_fwd();
        chk(f_ok && f_mask == m && f_read == rd && f_req == 2'(rq), tag,
            {f_ok, 3'b0, f_mask, 3'b0, f_read, 2'b0, f_req},
            {1'b1, 3'b0, m, 3'b0, rd, 2'b0, 2'(rq)});
    endtask

    task automatic expect_quiet(input string tag, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (rsp_valid || fwd_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset();
        chk(!rsp_valid && !fwd_valid && req_ready, "R1 reset outputs",
            {rsp_valid, fwd_valid, req_ready}, 3'b001);
    endtask

    task automatic t_read_shared();
        send_req(0, 0, ha(0));
        expect_rsp("R2 read of invalid line", 0, 32'hA000, 0);
        send_req(1, 0, ha(0));
        expect_rsp("R2 read of shared line", 1, 32'hA000, 0);
    endtask

    task automatic t_write_inval();
        send_req(2, 1, ha(0));
        expect_fwd("R4 invalidate only the sharers", 4'b0011, 0, 2);
        send_ack(0, 0, 0, 0);
        send_ack(0, 0, 0, 0);
        expect_quiet("R9 repeated ack not counted", 4);
        send_ack(1, 0, 0, 0);
        expect_rsp("R4 grant after all acks", 2, 32'hA000, 1);
    endtask

    task automatic t_read_modified();
        send_req(3, 0, ha(0));
        expect_fwd("R3 forward read to owner", 4'b0100, 1, 3);
        send_ack(2, 0, 1, 32'h1234);
        expect_rsp("R3 data from owner writeback", 3, 32'h1234, 0);
        send_req(0, 0, ha(0));
        expect_rsp("R2 memory holds written-back data", 0, 32'h1234, 0);
        send_req(1, 1, ha(0));
        expect_fwd("R4 invalidate three sharers", 4'b1101, 0, 1);
        send_ack(0, 0, 0, 0);
        send_ack(2, 0, 0, 0);
        send_ack(3, 0, 0, 0);
        expect_rsp("R4 grant after three acks", 1, 32'h1234, 1);
    endtask

    task automatic t_upgrade();
        send_req(1, 0, ha(1));
        expect_rsp("R2 read line 1", 1, 32'hA001, 0);
        send_req(1, 1, ha(1));
        expect_rsp("R5 sole sharer upgrade", 1, 32'hA001, 1);
        chk(!g_sawfwd, "R5 no forward on upgrade", g_sawfwd, 0);
    endtask

    task automatic t_queue_order();
        send_req(0, 1, ha(2));
        expect_rsp("R5 write to invalid line", 0, 32'hA002, 1);
        send_req(1, 0, ha(2));
        expect_fwd("R3 forward to owner P0", 4'b0001, 1, 1);
        send_req(2, 0, ha(2));
        expect_quiet("R6 queued read waits for ack", 5);
        send_ack(0, 2, 1, 32'h5555);
        expect_rsp("R6 first request completes", 1, 32'h5555, 0);
        expect_rsp("R6 queued request served next", 2, 32'h5555, 0);
        send_ack(3, 2, 1, 32'h9999);
        send_req(3, 0, ha(2));
        expect_rsp("R9 stray ack data ignored", 3, 32'h5555, 0);
    endtask

    task automatic t_foreign();
        send_req(0, 0, 3'b000);
        expect_quiet("R8 foreign home dropped", 6);
        chk(req_ready, "R8 queue untouched", req_ready, 1);
    endtask

    task automatic t_full();
        send_req(0, 1, ha(3));
        expect_rsp("R5 write line 3", 0, 32'hA003, 1);
        send_req(1, 0, ha(3));
        expect_fwd("R3 forward line 3", 4'b0001, 1, 1);
        send_req(2, 0, ha(3));
        send_req(3, 0, ha(3));
        send_req(2, 0, ha(3));
        send_req(3, 0, ha(3));
        chk(!req_ready, "R7 ready low when full", req_ready, 0);
        send_ack(0, 3, 1, 32'h7777);
        expect_rsp("R10 completion before queued work", 1, 32'h7777, 0);
        expect_rsp("R7 drain 1", 2, 32'h7777, 0);
        expect_rsp("R7 drain 2", 3, 32'h7777, 0);
        expect_rsp("R7 drain 3", 2, 32'h7777, 0);
        expect_rsp("R7 drain 4", 3, 32'h7777, 0);
        chk(req_ready, "R7 ready back after drain", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_shared();
        t_write_inval();
        t_read_modified();
        t_upgrade();
        t_queue_order();
        t_foreign();
        t_full();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule